// File: doc/BRIEF.md
# Multi-Channel DMA Control and Status Register File

This block is the shared register file that sits beside a bank of DMA channel engines. It collects per-channel event pulses from those engines: a completion, a termination and a bus error. From them it keeps sticky completion flags and sticky fault flags. It drives one interrupt line per channel, plus per-channel freeze levels and single-cycle channel reset pulses. It also holds two global burst-mode enables. Software reaches all of this through a simple word-addressed bus with a write strobe and a combinational read port.

Each control word has four word addresses. The first takes a direct write. The second ORs the written ones into the word. The third clears the written ones. The fourth ignores writes. All four return the current value on a read. Software can therefore change one channel's bit without a read-modify-write race against the engines. A termination that arrives in the same cycle as a completion of the same channel counts as a normal end, not as a fault.

Top module: `dmareg_csr`

## Requirements
- R1: After reset every register reads zero, and `irq`, `freeze`, `chan_rst`, `burst_en` and `burst8_en` are all low.
- R2: The register index is addr[5:2]: 0 is global config, 1 is completion, 2 is fault and 3 is channel control. The offset addr[1:0] selects the write action: 0 replaces the word, 1 ORs in the written ones, 2 clears the written ones and 3 ignores the write. A read at any offset returns the word. Addresses with addr[5:4] nonzero read zero, and writes to them change nothing.
- R3: A `done_evt` pulse on channel i sets completion bit i (bits 15:0), and the bit reads back from the first cycle after the pulse. Completion word bits 31:16 are the per-channel interrupt enables.
- R4: `irq[i]` is high exactly when fault bit i is set, or when completion bit i and enable bit 16+i are both set. It follows the registers with no further delay.
- R5: A `buserr_evt`, or a `term_evt` without a `done_evt` in the same cycle, sets fault bit i (bits 15:0). It also loads status bit 16+i with 1 for a bus error and 0 for a termination; a bus error wins when both arrive together. A termination that comes with a completion sets no fault bit.
- R6: When an event sets a flag in the same cycle that software clears that flag, the flag ends up set.
- R7: Channel control bits 15:0 are read/write freeze bits and drive `freeze` directly.
- R8: Writing a 1 to channel control bit 16+i (direct or set offset) makes `chan_rst[i]` high for exactly the next cycle. The bit reads 1 during that cycle only and then self-clears.
- R9: Config bit 28 drives `burst_en` and bit 29 drives `burst8_en`. All other config bits read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for the register bus |
| addr | input | 6 | Word address (register index and alias offset) |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| done_evt | input | 16 | Per-channel completion pulses |
| term_evt | input | 16 | Per-channel termination pulses |
| buserr_evt | input | 16 | Per-channel bus-error pulses |
| irq | output | 16 | Per-channel interrupt lines |
| freeze | output | 16 | Per-channel freeze levels |
| chan_rst | output | 16 | Per-channel single-cycle reset pulses |
| burst_en | output | 1 | Global burst enable |
| burst8_en | output | 1 | Global eight-word burst enable |

## Verification
Every flag, enable and freeze bit, and every reset pulse, takes effect at the single clock edge that follows its write or event. `irq` and `rdata` are combinational from those registers, so results are due one cycle after the stimulus. The bench drives each stimulus on a falling edge and releases it on the next falling edge, then samples at that point: one rising edge has passed. Reset pulses are checked at that sample and again one cycle later, when they must have gone. Same-cycle collisions between an event and a clear are driven within a single stimulus cycle.

// File: rtl/dmareg_pkg.sv
package dmareg_pkg;
   localparam int WORD_W = 32;
   localparam int HALF_W = WORD_W / 2;
   localparam int NREG   = 4;

   typedef enum logic [1:0] {
      ALIAS_WRITE = 2'd0,
      ALIAS_SET   = 2'd1,
      ALIAS_CLEAR = 2'd2,
      ALIAS_NONE  = 2'd3
   } alias_e;

   typedef enum logic [1:0] {
      REG_CFG   = 2'd0,
      REG_DONE  = 2'd1,
      REG_FAULT = 2'd2,
      REG_CHAN  = 2'd3
   } reg_e;
endpackage

// File: rtl/dmareg_dec.sv
module dmareg_dec
   import dmareg_pkg::*;
#(
   parameter int AW = 6
) (
   input  logic          wr_en,
   input  logic [AW-1:0] addr,
   output logic [NREG-1:0] wr_sel,
   output alias_e        mode,
   output reg_e          rsel,
   output logic          rvalid
);
   localparam int IDX_LSB = 2;

   logic in_map;

   generate
      if (AW > 4) begin : g_hi
         assign in_map = (addr[AW-1:4] == '0);
      end else begin : g_nohi
         assign in_map = 1'b1;
      end
   endgenerate

   assign mode   = alias_e'(addr[1:0]);
   assign rsel   = reg_e'(addr[IDX_LSB+1:IDX_LSB]);
   assign rvalid = in_map;

   always_comb begin
      wr_sel = '0;
      if (wr_en && in_map && mode != ALIAS_NONE)
         wr_sel[rsel] = 1'b1;
   end
endmodule

// File: rtl/dmareg_field.sv
module dmareg_field
   import dmareg_pkg::*;
#(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr,
   input  alias_e       mode,
   input  logic [W-1:0] wdata,
   input  logic [W-1:0] hw_load,
   input  logic [W-1:0] hw_val,
   output logic [W-1:0] q
);
   logic [W-1:0] sw_next;
   logic [W-1:0] nxt;

   always_comb begin
      sw_next = q;
      if (wr) begin
         case (mode)
            ALIAS_WRITE: sw_next = wdata;
            ALIAS_SET:   sw_next = q | wdata;
            ALIAS_CLEAR: sw_next = q & ~wdata;
            default:     sw_next = q;
         endcase
      end
      nxt = (sw_next & ~hw_load) | (hw_val & hw_load);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= nxt;
   end
endmodule

// File: rtl/dmareg_evt_class.sv
module dmareg_evt_class #(
   parameter int NCH = 16
) (
   input  logic [NCH-1:0] done_evt,
   input  logic [NCH-1:0] term_evt,
   input  logic [NCH-1:0] buserr_evt,
   output logic [NCH-1:0] fault_set,
   output logic [NCH-1:0] fault_kind
);
   for (genvar i = 0; i < NCH; i++) begin : g_ch
      assign fault_set[i]  = buserr_evt[i] | (term_evt[i] & ~done_evt[i]);
      assign fault_kind[i] = buserr_evt[i];
   end
endmodule

// File: rtl/dmareg_csr.sv
module dmareg_csr
   import dmareg_pkg::*;
#(
   parameter int NCH        = 16,
   parameter int AW         = 6,
   parameter int BURST_BIT  = 28,
   parameter int BURST8_BIT = 29
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [AW-1:0]     addr,
   input  logic [WORD_W-1:0] wdata,
   output logic [WORD_W-1:0] rdata,
   input  logic [NCH-1:0]    done_evt,
   input  logic [NCH-1:0]    term_evt,
   input  logic [NCH-1:0]    buserr_evt,
   output logic [NCH-1:0]    irq,
   output logic [NCH-1:0]    freeze,
   output logic [NCH-1:0]    chan_rst,
   output logic              burst_en,
   output logic              burst8_en
);
   localparam int CFG_W = 2;

   generate
      if (NCH < 1 || NCH > HALF_W) begin : g_bad_nch
         $error("dmareg_csr: NCH must be 1..16");
      end
      if (AW < 4) begin : g_bad_aw
         $error("dmareg_csr: AW must be at least 4");
      end
      if (BURST_BIT == BURST8_BIT || BURST_BIT >= WORD_W || BURST8_BIT >= WORD_W) begin : g_bad_cfg
         $error("dmareg_csr: burst bit positions invalid");
      end
   endgenerate

   logic [NREG-1:0] wr_sel;
   alias_e          mode;
   reg_e            rsel;
   logic            rvalid;

   dmareg_dec #(.AW(AW)) u_dec (
      .wr_en  (wr_en),
      .addr   (addr),
      .wr_sel (wr_sel),
      .mode   (mode),
      .rsel   (rsel),
      .rvalid (rvalid)
   );

   logic [NCH-1:0] fault_set;
   logic [NCH-1:0] fault_kind;

   dmareg_evt_class #(.NCH(NCH)) u_cls (
      .done_evt   (done_evt),
      .term_evt   (term_evt),
      .buserr_evt (buserr_evt),
      .fault_set  (fault_set),
      .fault_kind (fault_kind)
   );

   logic [CFG_W-1:0] cfg_q;
   logic [NCH-1:0]   done_q;
   logic [NCH-1:0]   en_q;
   logic [NCH-1:0]   fault_q;
   logic [NCH-1:0]   kind_q;
   logic [NCH-1:0]   frz_q;
   logic [NCH-1:0]   rst_q;
   logic [NCH-1:0]   lo_bits;
   logic [NCH-1:0]   hi_bits;

   assign lo_bits = wdata[NCH-1:0];
   assign hi_bits = wdata[HALF_W +: NCH];

   dmareg_field #(.W(CFG_W)) u_cfg (
      .clk (clk), .rst_n (rst_n), .wr (wr_sel[REG_CFG]), .mode (mode),
      .wdata ({wdata[BURST8_BIT], wdata[BURST_BIT]}),
      .hw_load ('0), .hw_val ('0), .q (cfg_q)
   );

   dmareg_field #(.W(NCH)) u_done (
      .clk (clk), .rst_n (rst_n), .wr (wr_sel[REG_DONE]), .mode (mode),
      .wdata (lo_bits), .hw_load (done_evt), .hw_val ('1), .q (done_q)
   );

   dmareg_field #(.W(NCH)) u_en (
      .clk (clk), .rst_n (rst_n), .wr (wr_sel[REG_DONE]), .mode (mode),
      .wdata (hi_bits), .hw_load ('0), .hw_val ('0), .q (en_q)
   );

   dmareg_field #(.W(NCH)) u_fault (
      .clk (clk), .rst_n (rst_n), .wr (wr_sel[REG_FAULT]), .mode (mode),
      .wdata (lo_bits), .hw_load (fault_set), .hw_val ('1), .q (fault_q)
   );

   dmareg_field #(.W(NCH)) u_kind (
      .clk (clk), .rst_n (rst_n), .wr (wr_sel[REG_FAULT]), .mode (mode),
      .wdata (hi_bits), .hw_load (fault_set), .hw_val (fault_kind), .q (kind_q)
   );

   dmareg_field #(.W(NCH)) u_frz (
      .clk (clk), .rst_n (rst_n), .wr (wr_sel[REG_CHAN]), .mode (mode),
      .wdata (lo_bits), .hw_load ('0), .hw_val ('0), .q (frz_q)
   );

   // Reset requests live for one cycle: only a write in this cycle refills them.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rst_q <= '0;
      else if (wr_sel[REG_CHAN] && (mode == ALIAS_WRITE || mode == ALIAS_SET))
         rst_q <= hi_bits;
      else
         rst_q <= '0;
   end

   for (genvar i = 0; i < NCH; i++) begin : g_irq
      assign irq[i] = (done_q[i] & en_q[i]) | fault_q[i];
   end

   assign freeze    = frz_q;
   assign chan_rst  = rst_q;
   assign burst_en  = cfg_q[0];
   assign burst8_en = cfg_q[1];

   always_comb begin
      rdata = '0;
      if (rvalid) begin
         case (rsel)
            REG_CFG: begin
               rdata[BURST_BIT]  = cfg_q[0];
               rdata[BURST8_BIT] = cfg_q[1];
            end
            REG_DONE: begin
               rdata[NCH-1:0]      = done_q;
               rdata[HALF_W +: NCH] = en_q;
            end
            REG_FAULT: begin
               rdata[NCH-1:0]      = fault_q;
               rdata[HALF_W +: NCH] = kind_q;
            end
            default: begin
               rdata[NCH-1:0]      = frz_q;
               rdata[HALF_W +: NCH] = rst_q;
            end
         endcase
      end
   end
endmodule

// File: rtl/dmareg_csr_chk.sv
module dmareg_csr_chk #(
   parameter int NCH = 16
) (
   input logic           clk,
   input logic           rst_n,
   input logic           wr_en,
   input logic [NCH-1:0] done_evt,
   input logic [NCH-1:0] term_evt,
   input logic [NCH-1:0] buserr_evt,
   input logic [NCH-1:0] irq,
   input logic [NCH-1:0] chan_rst,
   input logic [NCH-1:0] done_q,
   input logic [NCH-1:0] fault_q
);
   logic [NCH-1:0] fault_evt;
   assign fault_evt = buserr_evt | (term_evt & ~done_evt);

   // R3 R6
   done_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|done_evt) |=> ((done_q & $past(done_evt)) == $past(done_evt)));

   // R5 R6
   fault_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|fault_evt) |=> ((fault_q & $past(fault_evt)) == $past(fault_evt)));

   // R5
   no_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en && fault_evt == '0) |=> (fault_q == $past(fault_q)));

   // R8
   rst_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|chan_rst) |-> $past(wr_en));

   // R4
   irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en && done_evt == '0 && term_evt == '0 && buserr_evt == '0) |=> $stable(irq));
endmodule

bind dmareg_csr dmareg_csr_chk #(.NCH(NCH)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .wr_en      (wr_en),
   .done_evt   (done_evt),
   .term_evt   (term_evt),
   .buserr_evt (buserr_evt),
   .irq        (irq),
   .chan_rst   (chan_rst),
   .done_q     (done_q),
   .fault_q    (fault_q)
);

// File: tb/dmareg_csr_tb.sv
`timescale 1ns/1ps
module dmareg_csr_tb;
   localparam int NCH = 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [5:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic [NCH-1:0] done_evt = '0, term_evt = '0, buserr_evt = '0;
   logic [NCH-1:0] irq, freeze, chan_rst;
   logic        burst_en, burst8_en;

   int n_chk = 0;
   int n_fail = 0;

   always #10 clk = ~clk;

   dmareg_csr u_dut (
      .clk (clk), .rst_n (rst_n), .wr_en (wr_en), .addr (addr),
      .wdata (wdata), .rdata (rdata), .done_evt (done_evt),
      .term_evt (term_evt), .buserr_evt (buserr_evt), .irq (irq),
      .freeze (freeze), .chan_rst (chan_rst), .burst_en (burst_en),
      .burst8_en (burst8_en)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [5:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0; wdata = '0;
   endtask

   task automatic rd(input logic [5:0] a, output logic [31:0] d);
      addr = a;
      #1 d = rdata;
   endtask

   task automatic evt(input logic [NCH-1:0] dn, input logic [NCH-1:0] tm, input logic [NCH-1:0] be);
      @(negedge clk);
      done_evt = dn; term_evt = tm; buserr_evt = be;
      @(negedge clk);
      done_evt = '0; term_evt = '0; buserr_evt = '0;
   endtask

   initial begin
      #(200000 * 20);
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      logic [31:0] d;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk("R1 irq", 32'(irq), 0);
      chk("R1 freeze", 32'(freeze), 0);
      chk("R1 chan_rst", 32'(chan_rst), 0);
      chk("R1 burst", {30'd0, burst8_en, burst_en}, 0);
      for (int a = 0; a < 16; a++) begin
         rd(6'(a), d);
         chk("R1 read", d, 0);
      end

      // R9 config bits, R2 alias offsets
      wr(6'd0, 32'hFFFF_FFFF);
      rd(6'd0, d); chk("R9 cfg readback", d, 32'h3000_0000);
      chk("R9 burst pins", {30'd0, burst8_en, burst_en}, 3);
      wr(6'd2, 32'h1000_0000);
      rd(6'd1, d); chk("R2 cfg clear alias", d, 32'h2000_0000);
      chk("R9 burst_en low", {30'd0, burst8_en, burst_en}, 2);
      wr(6'd3, 32'h0000_0000);
      rd(6'd3, d); chk("R2 offset3 ignored", d, 32'h2000_0000);
      wr(6'd0, 32'h0);

      for (int i = 0; i < NCH; i++) begin
         logic [31:0] lo, hi;
         lo = 32'd1 << i;
         hi = 32'd1 << (16 + i);
         // R3 R4 completion with enable
         wr(6'd5, hi);
         evt(NCH'(lo), '0, '0);
         rd(6'd4, d); chk("R3 done flag", d, hi | lo);
         chk("R4 irq enabled", 32'(irq), lo);
         wr(6'd6, lo);
         rd(6'd7, d); chk("R2 done clear", d, hi);
         chk("R4 irq after clear", 32'(irq), 0);
         wr(6'd6, hi);
         evt(NCH'(lo), '0, '0);
         rd(6'd4, d); chk("R3 done no enable", d, lo);
         chk("R4 irq masked", 32'(irq), 0);
         wr(6'd6, lo);
         // R5 termination only
         evt('0, NCH'(lo), '0);
         rd(6'd8, d); chk("R5 term fault", d, lo);
         chk("R4 irq fault", 32'(irq), lo);
         wr(6'd10, lo);
         rd(6'd8, d); chk("R5 fault cleared", d, 0);
         // R5 bus error (with termination too)
         evt('0, NCH'(lo), NCH'(lo));
         rd(6'd9, d); chk("R5 buserr fault", d, hi | lo);
         wr(6'd10, 32'hFFFF_FFFF);
         rd(6'd8, d); chk("R5 fault all clear", d, 0);
         // R5 termination with completion is no fault
         evt(NCH'(lo), NCH'(lo), '0);
         rd(6'd8, d); chk("R5 term+done no fault", d, 0);
         rd(6'd4, d); chk("R5 term+done completion", d, lo);
         wr(6'd6, lo);
         // R7 freeze
         wr(6'd13, lo);
         chk("R7 freeze set", 32'(freeze), lo);
         wr(6'd14, lo);
         chk("R7 freeze clear", 32'(freeze), 0);
         // R8 reset pulse
         wr(6'd13, hi);
         chk("R8 pulse", 32'(chan_rst), lo);
         rd(6'd12, d); chk("R8 readback", d, hi);
         @(negedge clk);
         chk("R8 pulse ends", 32'(chan_rst), 0);
         rd(6'd12, d); chk("R8 self clear", d, 0);
      end

      // R8 direct write form
      wr(6'd12, 32'h8000_0001);
      chk("R8 direct pulse", 32'(chan_rst), 32'h8000);
      chk("R7 direct freeze", 32'(freeze), 1);
      wr(6'd12, 0);

      // R6 event vs clear in the same cycle
      @(negedge clk);
      done_evt = 16'h0008; wr_en = 1'b1; addr = 6'd6; wdata = 32'h0000_0009;
      @(negedge clk);
      done_evt = '0; wr_en = 1'b0;
      rd(6'd4, d); chk("R6 done set wins", d, 32'h0000_0008);
      @(negedge clk);
      buserr_evt = 16'h0020; wr_en = 1'b1; addr = 6'd10; wdata = 32'hFFFF_FFFF;
      @(negedge clk);
      buserr_evt = '0; wr_en = 1'b0;
      rd(6'd8, d); chk("R6 fault set wins", d, 32'h0020_0020);

      // R2 direct write, unmapped space
      wr(6'd4, 32'h0003_00A5);
      rd(6'd4, d); chk("R2 direct write", d, 32'h0003_00A5);
      chk("R4 irq mixed", 32'(irq), 32'h0000_0021);
      wr(6'd20, 32'hFFFF_FFFF);
      wr(6'd61, 32'hFFFF_FFFF);
      rd(6'd20, d); chk("R2 unmapped read", d, 0);
      rd(6'd4, d); chk("R2 unmapped write done", d, 32'h0003_00A5);
      rd(6'd0, d); chk("R2 unmapped write cfg", d, 0);
      chk("R2 unmapped write freeze", 32'(freeze), 0);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule